// File: doc/BRIEF.md
# Subcarrier Manchester Tag Response Decoder

This block turns a stream of 4-bit oversampled nibbles into the bytes of a tag-to-reader response. Each nibble covers one half bit period, and each set bit marks subcarrier modulation seen by the envelope detector upstream. While idle, the decoder picks a sample position inside the nibble and locks to it. Locking needs a sustained burst. The decoder then checks a fixed start-of-frame pattern over three bit periods.

After start of frame, each bit period is classed by which of its two halves carries modulation. That class gives a data bit, the end of the frame, or an error. Bits are packed LSB first into bytes, and each byte is written to a byte-buffer port at its index in the frame. An odd-parity bit is computed for each complete byte and collected in a parity word. A trailing partial byte is right-aligned before it is written.

When the frame ends, a one-clock done pulse presents the frame length and the parity word. The chosen sample offset is held on its own output. Error markers are written to the buffer port and do not complete a frame.

Top module: `subc_tag_decoder`

## Requirements
- R1: While idle, the sync position is the highest set bit of the incoming nibble (bit 3 down to bit 0). The decoder locks only if that bit is also set in each of the two nibbles received before it. On the locking edge, `sync_ofs` takes the position value (3, 2, 1 or 0) and holds it until the next lock.
- R2: A half period counts as modulated if the nibble bit at the sync position is set. It also counts if the bit one below is set, and for position 0 the bit one below is bit 3 of the previous nibble.
- R3: The locking nibble is the first half of the first start-of-frame period. The three start-of-frame periods must be both halves, then second half only, then second half only. Any other period writes marker 0xAB and enters error wait, with no done pulse.
- R4: After start of frame, a period modulated in the second half only is a 1 and one modulated in the first half only is a 0. Bits are packed LSB first. Each eighth bit writes the byte at address equal to its index in the frame.
- R5: Each complete byte shifts one bit into the LSB of the parity word. The bit is 1 when the byte holds an even number of ones.
- R6: A period with both halves modulated ends the frame with a done pulse carrying length and parity. If two or more bits are pending, they are written right-aligned as one more byte and a 0 is shifted into the parity word. A single pending bit is discarded.
- R7: An unmodulated period directly after start of frame writes byte 0x0F and ends the frame with length 1 and parity word 1. An unmodulated period at any later point enters error wait, with no write and no done pulse.
- R8: An end-of-frame period before any data bit writes marker 0xAD and enters error wait, with no done pulse.
- R9: In error wait, the next nibble returns the decoder to idle and is never used for locking. The nibble after it may lock.
- R10: `wr_en` and `frame_done` pulse for one clock, only after an edge with `smp_valid` high. Clocks with `smp_valid` low change no decoder state.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A new nibble is on `smp_nib` |
| smp_nib | input | 4 | Oversampled modulation flags for one half bit period |
| wr_en | output | 1 | Byte-buffer write strobe |
| wr_addr | output | 5 | Byte-buffer write address |
| wr_data | output | 8 | Byte or marker being written |
| frame_done | output | 1 | One-clock end-of-frame pulse |
| frame_len | output | 6 | Bytes in the completed frame |
| frame_par | output | 32 | Parity word of the completed frame |
| sync_ofs | output | 2 | Sample offset chosen at lock |

## Verification
Half-phase tracking is the most fragile state. If it slips by one nibble, every later period is classed wrongly: a correct frame then shows 0xAB or 0xAD on the write port within one or two bit periods, or the done pulse fails to appear. A wrong bit count or shift shows up as a wrong `wr_data` or `wr_addr` on the very next byte write. A bad parity update shows in `frame_par` at the done pulse. Because the reference model is compared every clock, an early or extra strobe is flagged in the clock where it appears.

// File: rtl/subc_dec_pkg.sv
// Shared types and constants of the subcarrier tag response decoder.
// Assumes 8-bit bytes; marker values are fixed by the frame behaviour.
package subc_dec_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] MARK_SOF_BAD = 8'hAB;
    localparam logic [BYTE_W-1:0] MARK_EMPTY   = 8'hAD;
    localparam logic [BYTE_W-1:0] BYTE_SHORT   = 8'h0F;

    // bit period class, encoded as {first half modulated, second half modulated}
    typedef enum logic [1:0] {
        PC_NONE   = 2'b00,
        PC_SECOND = 2'b01,
        PC_FIRST  = 2'b10,
        PC_BOTH   = 2'b11
    } period_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF1,
        ST_SOF2,
        ST_SOF3,
        ST_SOFOK,
        ST_DATA,
        ST_ERRW
    } dstate_t;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_CLEAR,
        CMD_BIT0,
        CMD_BIT1,
        CMD_EOF,
        CMD_SHORT,
        CMD_MARK_SOF,
        CMD_MARK_EMPTY
    } cmd_t;

endpackage

// File: rtl/subc_front.sv
// Sample front end: keeps the two previous nibbles, finds the sync position
// of an incoming nibble, and reports modulation at the selected position.
// Assumes one nibble per smp_valid strobe; history only moves on a strobe.
module subc_front #(
    parameter int SMP_W = 4,
    localparam int POS_W = $clog2(SMP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_valid,
    input  logic [SMP_W-1:0] nib,
    input  logic [POS_W-1:0] sel_pos,
    output logic             hit,
    output logic [POS_W-1:0] hit_pos,
    output logic             mod
);

    logic [SMP_W-1:0] hist1;
    logic [SMP_W-1:0] hist2;
    logic [SMP_W-1:0] below;
    logic             found;

    // history of the two previous nibbles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist1 <= '0;
            hist2 <= '0;
        end else if (nib_valid) begin
            hist2 <= hist1;
            hist1 <= nib;
        end
    end

    // highest set bit of the nibble, confirmed in both history nibbles
    always_comb begin
        hit_pos = '0;
        found   = 1'b0;
        for (int i = SMP_W - 1; i >= 0; i--) begin
            if (!found && nib[i]) begin
                hit_pos = POS_W'(i);
                found   = 1'b1;
            end
        end
        hit = found && hist1[hit_pos] && hist2[hit_pos];
    end

    // modulation at the chosen position, including the neighbour below it
    always_comb begin
        below = {nib[SMP_W-2:0], hist1[SMP_W-1]};
        mod   = nib[sel_pos] | below[sel_pos];
    end

endmodule

// File: rtl/subc_bytes.sv
// Byte assembler: packs bits LSB first, writes bytes and markers to the
// buffer port, keeps length and parity, and raises the done pulse.
// Assumes the frame controller issues at most one command per clock.
module subc_bytes
    import subc_dec_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int PAR_W  = 32,
    localparam int LEN_W = ADDR_W + 1,
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd,
    output logic              empty,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              frame_done,
    output logic [LEN_W-1:0]  frame_len,
    output logic [PAR_W-1:0]  frame_par
);

    logic [BYTE_W:0]     sr;
    logic [BYTE_W:0]     sr_shift;
    logic [CNT_W-1:0]    bcnt;
    logic [LEN_W-1:0]    len;
    logic [PAR_W-1:0]    par;
    logic [BYTE_W-1:0]   part_byte;
    logic [CNT_W-1:0]    shamt;
    logic                full;

    // next register value, byte-complete flag and right-aligned partial byte
    always_comb begin
        sr_shift  = {cmd == CMD_BIT1, sr[BYTE_W:1]};
        full      = (bcnt == CNT_W'(BYTE_W - 1));
        shamt     = CNT_W'(BYTE_W + 1) - bcnt;
        part_byte = BYTE_W'(sr >> shamt);
        empty     = (len == '0) && (bcnt == '0);
    end

    // command execution
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr         <= '0;
            bcnt       <= '0;
            len        <= '0;
            par        <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            frame_done <= 1'b0;
            frame_len  <= '0;
            frame_par  <= '0;
        end else begin
            wr_en      <= 1'b0;
            frame_done <= 1'b0;
            case (cmd)
                CMD_CLEAR: begin
                    sr   <= '0;
                    bcnt <= '0;
                    len  <= '0;
                    par  <= '0;
                end
                CMD_BIT0, CMD_BIT1: begin
                    sr <= sr_shift;
                    if (full) begin
                        bcnt    <= '0;
                        wr_en   <= 1'b1;
                        wr_addr <= len[ADDR_W-1:0];
                        wr_data <= sr_shift[BYTE_W:1];
                        len     <= len + LEN_W'(1);
                        par     <= {par[PAR_W-2:0], ~^sr_shift[BYTE_W:1]};
                    end else begin
                        bcnt <= bcnt + CNT_W'(1);
                    end
                end
                CMD_EOF: begin
                    frame_done <= 1'b1;
                    if (bcnt > CNT_W'(1)) begin
                        wr_en     <= 1'b1;
                        wr_addr   <= len[ADDR_W-1:0];
                        wr_data   <= part_byte;
                        len       <= len + LEN_W'(1);
                        par       <= {par[PAR_W-2:0], 1'b0};
                        frame_len <= len + LEN_W'(1);
                        frame_par <= {par[PAR_W-2:0], 1'b0};
                    end else begin
                        frame_len <= len;
                        frame_par <= par;
                    end
                    bcnt <= '0;
                end
                CMD_SHORT: begin
                    wr_en      <= 1'b1;
                    wr_addr    <= len[ADDR_W-1:0];
                    wr_data    <= BYTE_SHORT;
                    len        <= len + LEN_W'(1);
                    par        <= {par[PAR_W-2:0], 1'b1};
                    frame_done <= 1'b1;
                    frame_len  <= len + LEN_W'(1);
                    frame_par  <= {par[PAR_W-2:0], 1'b1};
                end
                CMD_MARK_SOF, CMD_MARK_EMPTY: begin
                    wr_en   <= 1'b1;
                    wr_addr <= len[ADDR_W-1:0];
                    wr_data <= (cmd == CMD_MARK_SOF) ? MARK_SOF_BAD : MARK_EMPTY;
                end
                default: ;
            endcase
        end
    end

    // length moves by one byte at a time or restarts at zero (R4)
    p_len_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (len != $past(len)) |-> (len == $past(len) + LEN_W'(1) || len == '0));

    // a partial byte is only written together with the end of the frame (R6)
    p_pending_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && wr_en) |-> (wr_addr == $past(len[ADDR_W-1:0])));

endmodule

// File: rtl/subc_frame.sv
// Frame controller: locks on a sync position, pairs half periods into bit
// periods, checks the start-of-frame pattern and issues assembler commands.
// Assumes the front end reports modulation for the currently held position.
module subc_frame
    import subc_dec_pkg::*;
#(
    parameter int SMP_W = 4,
    localparam int POS_W = $clog2(SMP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_valid,
    input  logic             hit,
    input  logic [POS_W-1:0] hit_pos,
    input  logic             mod,
    input  logic             empty,
    output logic [POS_W-1:0] sel_pos,
    output cmd_t             cmd,
    output logic [POS_W-1:0] sync_ofs
);

    dstate_t          state;
    dstate_t          st_n;
    logic             second;
    logic             first_mod;
    logic [POS_W-1:0] pos_q;
    period_t          cls;

    assign sel_pos  = pos_q;
    assign sync_ofs = pos_q;

    // next state and command for this nibble
    always_comb begin
        cls  = period_t'({first_mod, mod});
        cmd  = CMD_NOP;
        st_n = state;
        if (nib_valid) begin
            case (state)
                ST_IDLE: begin
                    if (hit) begin
                        cmd  = CMD_CLEAR;
                        st_n = ST_SOF1;
                    end
                end
                ST_ERRW: st_n = ST_IDLE;
                ST_SOF1, ST_SOF2, ST_SOF3: begin
                    if (second) begin
                        if (state == ST_SOF1 && cls == PC_BOTH) begin
                            st_n = ST_SOF2;
                        end else if (state == ST_SOF2 && cls == PC_SECOND) begin
                            st_n = ST_SOF3;
                        end else if (state == ST_SOF3 && cls == PC_SECOND) begin
                            st_n = ST_SOFOK;
                        end else begin
                            cmd  = CMD_MARK_SOF;
                            st_n = ST_ERRW;
                        end
                    end
                end
                default: begin
                    if (second) begin
                        case (cls)
                            PC_SECOND: begin
                                cmd  = CMD_BIT1;
                                st_n = ST_DATA;
                            end
                            PC_FIRST: begin
                                cmd  = CMD_BIT0;
                                st_n = ST_DATA;
                            end
                            PC_BOTH: begin
                                if (empty) begin
                                    cmd  = CMD_MARK_EMPTY;
                                    st_n = ST_ERRW;
                                end else begin
                                    cmd  = CMD_EOF;
                                    st_n = ST_IDLE;
                                end
                            end
                            default: begin
                                if (state == ST_SOFOK) begin
                                    cmd  = CMD_SHORT;
                                    st_n = ST_IDLE;
                                end else begin
                                    st_n = ST_ERRW;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // state, half-period phase and held sync position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            second    <= 1'b0;
            first_mod <= 1'b0;
            pos_q     <= '0;
        end else begin
            state <= st_n;
            if (nib_valid) begin
                if (state == ST_IDLE) begin
                    if (hit) begin
                        pos_q     <= hit_pos;
                        second    <= 1'b1;
                        first_mod <= 1'b1;
                    end
                end else if (state != ST_ERRW) begin
                    if (!second) begin
                        first_mod <= mod;
                        second    <= 1'b1;
                    end else begin
                        second <= 1'b0;
                    end
                end
            end
        end
    end

    // the sync offset only changes while idle (R1)
    p_sync_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(pos_q));

    // the last start-of-frame step is only reached from the one before it (R3)
    p_sof_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOF3 && $past(state) != ST_SOF3) |-> ($past(state) == ST_SOF2));

    // error wait lasts exactly one nibble (R9)
    p_errw_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERRW && $past(state) == ST_ERRW) |-> !$past(nib_valid));

endmodule

// File: rtl/subc_tag_decoder.sv
// Top of the subcarrier Manchester tag response decoder: front end, frame
// controller and byte assembler. Assumes nibbles arrive one per smp_valid.
module subc_tag_decoder
    import subc_dec_pkg::*;
#(
    parameter int SMP_W  = 4,
    parameter int ADDR_W = 5,
    parameter int PAR_W  = 32,
    localparam int POS_W = $clog2(SMP_W),
    localparam int LEN_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_nib,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              frame_done,
    output logic [LEN_W-1:0]  frame_len,
    output logic [PAR_W-1:0]  frame_par,
    output logic [POS_W-1:0]  sync_ofs
);

    logic             hit;
    logic [POS_W-1:0] hit_pos;
    logic             mod;
    logic [POS_W-1:0] sel_pos;
    logic             empty;
    cmd_t             cmd;

    subc_front #(.SMP_W(SMP_W)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_valid (smp_valid),
        .nib       (smp_nib),
        .sel_pos   (sel_pos),
        .hit       (hit),
        .hit_pos   (hit_pos),
        .mod       (mod)
    );

    subc_frame #(.SMP_W(SMP_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_valid (smp_valid),
        .hit       (hit),
        .hit_pos   (hit_pos),
        .mod       (mod),
        .empty     (empty),
        .sel_pos   (sel_pos),
        .cmd       (cmd),
        .sync_ofs  (sync_ofs)
    );

    subc_bytes #(.ADDR_W(ADDR_W), .PAR_W(PAR_W)) u_bytes (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .empty      (empty),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_done (frame_done),
        .frame_len  (frame_len),
        .frame_par  (frame_par)
    );

    // done is a single-clock pulse (R10)
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // a write only follows an edge that carried a nibble (R10)
    p_write_on_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(smp_valid));

endmodule

// File: tb/subc_tag_decoder_test.sv
module subc_tag_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [3:0]  smp_nib = '0;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        frame_done;
    logic [5:0]  frame_len;
    logic [31:0] frame_par;
    logic [1:0]  sync_ofs;

    subc_tag_decoder uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_nib(smp_nib),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_done(frame_done), .frame_len(frame_len),
        .frame_par(frame_par), .sync_ofs(sync_ofs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit comparing = 0;
    string cur_req = "R11";

    // reference model state (0 idle,1..3 start of frame,4 just after,5 data,6 error wait)
    int m_state = 0;
    int m_h1 = 0, m_h2 = 0, m_pos = 0, m_sec = 0, m_fm = 0, m_len = 0;
    int m_bits[$];
    logic [31:0] m_par = '0;
    int e_wr_en = 0, e_addr = 0, e_data = 0, e_done = 0, e_len = 0, e_ofs = 0;
    logic [31:0] e_par = '0;

    // observations
    int n_done = 0, n_wr = 0, got_len = 0, last_wr = 0;
    logic [31:0] got_par = '0;

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int even_ones(input int b);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (b >> i) & 1;
        return (n % 2 == 0) ? 1 : 0;
    endfunction

    task automatic emit(input int b);
        e_wr_en = 1;
        e_addr = m_len % 32;
        e_data = b;
    endtask

    task automatic period(input int f, input int s);
        int b;
        case (m_state)
            1: if (f == 1 && s == 1) m_state = 2; else begin emit(8'hAB); m_state = 6; end
            2, 3: if (f == 0 && s == 1) m_state = m_state + 1; else begin emit(8'hAB); m_state = 6; end
            default: begin
                if (f != s) begin
                    m_bits.push_back(s);
                    m_state = 5;
                    if (m_bits.size() == 8) begin
                        b = 0;
                        foreach (m_bits[i]) b |= m_bits[i] << i;
                        emit(b);
                        m_len++;
                        m_par = {m_par[30:0], 1'(even_ones(b))};
                        m_bits.delete();
                    end
                end else if (f == 1) begin
                    if (m_len == 0 && m_bits.size() == 0) begin
                        emit(8'hAD);
                        m_state = 6;
                    end else begin
                        if (m_bits.size() > 1) begin
                            b = 0;
                            foreach (m_bits[i]) b |= m_bits[i] << i;
                            emit(b);
                            m_len++;
                            m_par = {m_par[30:0], 1'b0};
                        end
                        m_bits.delete();
                        e_done = 1; e_len = m_len; e_par = m_par;
                        m_state = 0;
                    end
                end else if (m_state == 4) begin
                    emit(8'h0F);
                    m_len++;
                    m_par = {m_par[30:0], 1'b1};
                    e_done = 1; e_len = m_len; e_par = m_par;
                    m_state = 0;
                end else begin
                    m_state = 6;
                end
            end
        endcase
    endtask

    task automatic model(input int nib);
        int p, m;
        e_wr_en = 0;
        e_done = 0;
        if (m_state == 0) begin
            p = -1;
            for (int i = 3; i >= 0; i--) if (p < 0 && ((nib >> i) & 1) == 1) p = i;
            if (p >= 0 && ((m_h1 >> p) & 1) == 1 && ((m_h2 >> p) & 1) == 1) begin
                m_state = 1; m_pos = p; e_ofs = p; m_sec = 1; m_fm = 1;
                m_bits.delete(); m_len = 0; m_par = '0;
            end
        end else if (m_state == 6) begin
            m_state = 0;
        end else begin
            m = ((nib >> m_pos) & 1) |
                ((m_pos == 0) ? ((m_h1 >> 3) & 1) : ((nib >> (m_pos - 1)) & 1));
            if (m_sec == 0) begin
                m_fm = m; m_sec = 1;
            end else begin
                m_sec = 0;
                period(m_fm, m);
            end
        end
        m_h2 = m_h1;
        m_h1 = nib;
    endtask

    task automatic compare();
        if (frame_done) begin n_done++; got_len = frame_len; got_par = frame_par; end
        if (wr_en) begin n_wr++; last_wr = wr_data; end
        check_eq(cur_req, "wr_en", wr_en, e_wr_en);
        check_eq(cur_req, "frame_done", frame_done, e_done);
        check_eq(cur_req, "sync_ofs", sync_ofs, e_ofs);
        check_eq(cur_req, "frame_len", frame_len, e_len);
        check_eq(cur_req, "frame_par", frame_par, e_par);
        if (e_wr_en != 0) begin
            check_eq(cur_req, "wr_addr", wr_addr, e_addr);
            check_eq(cur_req, "wr_data", wr_data, e_data);
        end
    endtask

    int gap = 0;

    task automatic step(input bit v, input int nib);
        @(negedge clk);
        if (comparing) compare();
        smp_valid = v;
        smp_nib = 4'(nib);
        if (v) model(nib);
        else begin e_wr_en = 0; e_done = 0; end
    endtask

    task automatic nib_in(input int nib);
        step(1, nib);
        for (int g = 0; g < gap; g++) step(0, 4'hF);
    endtask

    task automatic lock(input int hi);
        nib_in(0); nib_in(0); nib_in(hi); nib_in(hi); nib_in(hi);
    endtask

    task automatic sof(input int hi);
        nib_in(hi); nib_in(0); nib_in(hi); nib_in(0); nib_in(hi);
    endtask

    task automatic send_bit(input int b, input int hi);
        if (b != 0) begin nib_in(0); nib_in(hi); end
        else begin nib_in(hi); nib_in(0); end
    endtask

    task automatic send_byte(input int b, input int hi);
        for (int i = 0; i < 8; i++) send_bit((b >> i) & 1, hi);
    endtask

    task automatic eof(input int hi);
        nib_in(hi); nib_in(hi);
    endtask

    task automatic settle();
        step(0, 0); step(0, 0);
    endtask

    int d0;

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state of every output
        check_eq("R11", "wr_en", wr_en, 0);
        check_eq("R11", "frame_done", frame_done, 0);
        check_eq("R11", "frame_len", frame_len, 0);
        check_eq("R11", "frame_par", frame_par, 0);
        check_eq("R11", "sync_ofs", sync_ofs, 0);
        comparing = 1;

        // R4 R5 R6: two full bytes at offset 3
        cur_req = "R4";
        lock(4'hF); sof(4'hF);
        send_byte(8'hA5, 4'hF); send_byte(8'h3C, 4'hF); eof(4'hF); settle();
        check_eq("R1", "offset", sync_ofs, 3);
        check_eq("R6", "length", got_len, 2);
        check_eq("R5", "parity", got_par, 32'h3);
        check_eq("R4", "last byte", last_wr, 8'h3C);

        // R6: partial byte of three bits right-aligned
        cur_req = "R6";
        lock(4'hF); sof(4'hF);
        send_byte(8'h12, 4'hF); send_bit(1, 4'hF); send_bit(0, 4'hF); send_bit(1, 4'hF);
        eof(4'hF); settle();
        check_eq("R6", "partial length", got_len, 2);
        check_eq("R6", "partial parity", got_par, 32'h2);
        check_eq("R6", "partial byte", last_wr, 8'h05);

        // R6: a single pending bit is dropped
        lock(4'hF); sof(4'hF);
        send_byte(8'hFF, 4'hF); send_bit(1, 4'hF); eof(4'hF); settle();
        check_eq("R6", "single bit length", got_len, 1);
        check_eq("R6", "single bit last", last_wr, 8'hFF);

        // R7: empty period right after start of frame, offset 1
        cur_req = "R7";
        lock(4'h3); sof(4'h3); nib_in(0); nib_in(0); settle();
        check_eq("R1", "offset one", sync_ofs, 1);
        check_eq("R7", "short length", got_len, 1);
        check_eq("R7", "short parity", got_par, 32'h1);
        check_eq("R7", "short byte", last_wr, 8'h0F);

        // R3 then R9: bad second start-of-frame period, then error wait nibble ignored
        cur_req = "R3";
        d0 = n_done;
        lock(4'hF); nib_in(4'hF); nib_in(4'hF); nib_in(4'hF); settle();
        check_eq("R3", "sof marker", last_wr, 8'hAB);
        check_eq("R3", "no done", n_done, d0);
        cur_req = "R9";
        nib_in(4'hF); nib_in(4'hF);
        sof(4'hF); send_byte(8'h81, 4'hF); eof(4'hF); settle();
        check_eq("R9", "frame after wait", n_done, d0 + 1);
        check_eq("R9", "byte after wait", last_wr, 8'h81);

        // R8: end of frame before any data
        cur_req = "R8";
        d0 = n_done;
        lock(4'hF); sof(4'hF); eof(4'hF); settle();
        check_eq("R8", "empty marker", last_wr, 8'hAD);
        check_eq("R8", "no done", n_done, d0);
        nib_in(0);

        // R7: empty period inside data is an error without a write
        cur_req = "R7";
        d0 = n_done;
        lock(4'hF); sof(4'hF); send_bit(1, 4'hF);
        d0 = n_wr;
        nib_in(0); nib_in(0); nib_in(0); settle();
        check_eq("R7", "no write on late gap", n_wr, d0);

        // R2: offset 0 with modulation carried across the nibble boundary
        cur_req = "R2";
        lock(4'h1); sof(4'h1);
        nib_in(4'h1); nib_in(4'h8);
        nib_in(4'h0); nib_in(4'h0);
        for (int i = 0; i < 6; i++) send_bit(1, 4'h1);
        eof(4'h1); settle();
        check_eq("R1", "offset zero", sync_ofs, 0);
        check_eq("R2", "boundary byte", last_wr, 8'hFC);
        check_eq("R2", "boundary length", got_len, 1);

        // R10: idle clocks between nibbles change nothing
        cur_req = "R10";
        d0 = n_done;
        gap = 2;
        lock(4'hF); sof(4'hF); send_byte(8'h5A, 4'hF); eof(4'hF);
        gap = 0;
        settle();
        check_eq("R10", "one done", n_done, d0 + 1);
        check_eq("R10", "gapped byte", last_wr, 8'h5A);
        check_eq("R10", "gapped parity", got_par, 32'h1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule